// File: doc/BRIEF.md
# Auxiliary Channel Request Engine

This block lets a host processor compose a single sideband request for a display auxiliary channel through a small window of byte-wide registers, launch it, and later collect the outcome. The host programs a 20-bit target address, a 4-bit request code and a payload length. For writes it also loads the payload bytes one at a time. It then sets a send bit. The engine presents the request on a link-side handshake port and holds it there until the link side answers or a programmable cycle limit runs out.

The link side returns read bytes one per cycle, then a one-cycle reply carrying a 3-bit result code and a 5-bit byte count. The host polls the send bit until it drops, reads the packed status byte, and drains the reply bytes through the read-data register. A write of 0xFF to the channel configuration register flushes both byte buffers and the status, and abandons any request still in flight, so that the next request starts clean.

Request code encoding: bit 0 set means read and bit 0 clear means write; bit 3 set means native and bit 3 clear means I2C-over-AUX. The four codes in use are 0x8 (native write), 0x9 (native read), 0x0 (I2C write) and 0x1 (I2C read).

Top module: `aux_req_engine`

## Requirements
- R1: The address and length registers read back as written. Offset 0x7D holds address bits 7:0, 0x7E holds bits 15:8, and 0x7F holds address bits 19:16 in bits 3:0 and the request code in bits 7:4. The outputs `lnk_addr` and `lnk_cmd` carry these fields.
- R2: `lnk_len` is the length register bits 3:0 plus one (range 1 to 16). When bit 7 of the length register (offset 0x80) is set, `lnk_len` is 0.
- R3: Each idle write to offset 0x81 appends one byte to the payload buffer. While a request is pending, `lnk_tx_data` shows the byte at position `lnk_tx_idx` in write order.
- R4: A write with bit 0 set to offset 0x83 while idle raises `lnk_req` on the next cycle. While the request is pending, 0x83 reads 0x01 and the status register (offset 0x84) reads 0x00.
- R5: A `lnk_rsp_valid` pulse during a pending request drops `lnk_req` on the next cycle and clears bit 0 of 0x83. Status then reads {result[2:0], count[4:0]} from `lnk_rsp_status` and `lnk_rsp_count`.
- R6: While a read request (code bit 0 set) is pending, bytes on `lnk_rx_valid` go into the reply buffer. Each read of offset 0x82 returns the next byte in arrival order. Bytes offered during a write request are dropped.
- R7: A read of 0x82 with the reply buffer empty returns 0x00 and consumes nothing, so a byte that arrives later is still the first one returned.
- R8: While a request is pending, writes to 0x7D to 0x81 are ignored. The outgoing address, length and payload stay unchanged.
- R9: With no reply, the request stays pending for exactly `timeout_limit` cycles (a limit of 0 acts as 1). Status then reads 0xE0 (result 7, count 0) and the send bit reads 0.
- R10: A write of 0xFF to offset 0x76 empties both buffers, zeroes the status and drops `lnk_req` on the next cycle. Any other value written there has no effect.
- R11: After reset, `lnk_req` is low, and status, control and read data all read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| timeout_limit | input | TO_W | Reply wait limit in cycles |
| lnk_req | output | 1 | Request pending toward the link |
| lnk_cmd | output | 4 | Request code |
| lnk_addr | output | 20 | Request address |
| lnk_len | output | 5 | Payload length in bytes, 0 for no payload |
| lnk_tx_idx | input | IDX_W | Payload byte index chosen by the link |
| lnk_tx_data | output | 8 | Payload byte at `lnk_tx_idx` |
| lnk_rx_valid | input | 1 | Reply byte strobe |
| lnk_rx_data | input | 8 | Reply byte |
| lnk_rsp_valid | input | 1 | Reply complete pulse |
| lnk_rsp_status | input | 3 | Result code |
| lnk_rsp_count | input | 5 | Byte count reported by the link |

## Verification
The bench uses the defaults: 16-entry buffers and a 16-bit limit input. The full 1-to-16 payload range, a completely filled payload buffer and a reported count of 16 are therefore all reachable. The limit is held at 1000 for ordinary transfers, so responses are never cut short. It is lowered to 8 for one request, which makes the exact timeout cycle count observable on `lnk_req`.

// File: rtl/aux_eng_pkg.sv
package aux_eng_pkg;
  localparam logic [7:0] OFF_CFG   = 8'h76;
  localparam logic [7:0] OFF_ADR0  = 8'h7D;
  localparam logic [7:0] OFF_ADR1  = 8'h7E;
  localparam logic [7:0] OFF_ADR2  = 8'h7F;
  localparam logic [7:0] OFF_LEN   = 8'h80;
  localparam logic [7:0] OFF_WDATA = 8'h81;
  localparam logic [7:0] OFF_RDATA = 8'h82;
  localparam logic [7:0] OFF_CTRL  = 8'h83;
  localparam logic [7:0] OFF_STAT  = 8'h84;
  localparam logic [7:0] CFG_FLUSH = 8'hFF;

  typedef enum logic [2:0] {
    RES_NONE      = 3'd0,
    RES_NACK      = 3'd1,
    RES_DEFER     = 3'd2,
    RES_ACK       = 3'd3,
    RES_BADREQ    = 3'd4,
    RES_I2C_NACK  = 3'd5,
    RES_I2C_DEFER = 3'd6,
    RES_TIMEOUT   = 3'd7
  } aux_result_e;
endpackage

// File: rtl/aux_byte_buf.sv
// Byte queue with flush. DEPTH must be a power of two so pointers wrap.
module aux_byte_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic [AW-1:0] peek_idx,
  output logic [DW-1:0] head,
  output logic [DW-1:0] peek,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  assign head = mem[rp];
  assign peek = mem[rp + peek_idx];
endmodule

// File: rtl/aux_timeout.sv
// Counts cycles while run is high; expired when run has lasted limit cycles.
module aux_timeout #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = run && (({1'b0, cnt} + (W+1)'(1)) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (!expired) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
  import aux_eng_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int TO_W      = 16,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [TO_W-1:0]  timeout_limit,
  output logic             lnk_req,
  output logic [3:0]       lnk_cmd,
  output logic [19:0]      lnk_addr,
  output logic [4:0]       lnk_len,
  input  logic [IDX_W-1:0] lnk_tx_idx,
  output logic [7:0]       lnk_tx_data,
  input  logic             lnk_rx_valid,
  input  logic [7:0]       lnk_rx_data,
  input  logic             lnk_rsp_valid,
  input  logic [2:0]       lnk_rsp_status,
  input  logic [4:0]       lnk_rsp_count
);
  logic [19:0] addr_q;
  logic [3:0]  cmd_q;
  logic [7:0]  len_q;
  logic [7:0]  stat_q;
  logic [7:0]  rdata_q;
  logic        busy_q;

  logic flush, idle_wr, launch, expired;
  logic tx_push, rx_push, rx_pop;
  logic [7:0] tx_head, rx_head, rx_peek;
  logic tx_empty, tx_full, rx_empty, rx_full;

  assign flush   = reg_wr && (reg_addr == OFF_CFG) && (reg_wdata == CFG_FLUSH);
  assign idle_wr = reg_wr && !busy_q;
  assign launch  = idle_wr && (reg_addr == OFF_CTRL) && reg_wdata[0];
  assign tx_push = idle_wr && (reg_addr == OFF_WDATA);
  assign rx_push = busy_q && cmd_q[0] && lnk_rx_valid && !flush;
  assign rx_pop  = reg_rd && (reg_addr == OFF_RDATA);

  aux_byte_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_txbuf (
    .clk(clk), .rst(rst), .clr(flush),
    .push(tx_push), .din(reg_wdata), .pop(1'b0),
    .peek_idx(lnk_tx_idx), .head(tx_head), .peek(lnk_tx_data),
    .empty(tx_empty), .full(tx_full)
  );

  aux_byte_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_rxbuf (
    .clk(clk), .rst(rst), .clr(flush),
    .push(rx_push), .din(lnk_rx_data), .pop(rx_pop),
    .peek_idx('0), .head(rx_head), .peek(rx_peek),
    .empty(rx_empty), .full(rx_full)
  );

  aux_timeout #(.W(TO_W)) u_timer (
    .clk(clk), .rst(rst), .run(busy_q),
    .limit(timeout_limit), .expired(expired)
  );

  // Request lifecycle and status
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      stat_q <= '0;
    end else if (flush) begin
      busy_q <= 1'b0;
      stat_q <= '0;
    end else if (busy_q) begin
      if (lnk_rsp_valid) begin
        busy_q <= 1'b0;
        stat_q <= {lnk_rsp_status, lnk_rsp_count};
      end else if (expired) begin
        busy_q <= 1'b0;
        stat_q <= {RES_TIMEOUT, 5'd0};
      end
    end else if (launch) begin
      busy_q <= 1'b1;
      stat_q <= '0;
    end
  end

  // Request fields, writable only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cmd_q  <= '0;
      len_q  <= '0;
    end else if (idle_wr) begin
      case (reg_addr)
        OFF_ADR0: addr_q[7:0]   <= reg_wdata;
        OFF_ADR1: addr_q[15:8]  <= reg_wdata;
        OFF_ADR2: begin
          addr_q[19:16] <= reg_wdata[3:0];
          cmd_q         <= reg_wdata[7:4];
        end
        OFF_LEN:  len_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFF_ADR0:  rdata_q <= addr_q[7:0];
        OFF_ADR1:  rdata_q <= addr_q[15:8];
        OFF_ADR2:  rdata_q <= {cmd_q, addr_q[19:16]};
        OFF_LEN:   rdata_q <= len_q;
        OFF_RDATA: rdata_q <= rx_empty ? 8'h00 : rx_head;
        OFF_CTRL:  rdata_q <= {7'd0, busy_q};
        OFF_STAT:  rdata_q <= stat_q;
        default:   rdata_q <= 8'h00;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign lnk_req   = busy_q;
  assign lnk_cmd   = cmd_q;
  assign lnk_addr  = addr_q;
  assign lnk_len   = len_q[7] ? 5'd0 : ({1'b0, len_q[3:0]} + 5'd1);
endmodule

// File: rtl/aux_req_engine_chk.sv
module aux_req_engine_chk
  import aux_eng_pkg::*;
#(
  parameter int TO_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic [7:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [TO_W-1:0] timeout_limit,
  input logic            lnk_req,
  input logic [3:0]      lnk_cmd,
  input logic [19:0]     lnk_addr,
  input logic [4:0]      lnk_len,
  input logic            lnk_rsp_valid
);
  logic [TO_W:0] pend_cnt;
  logic [TO_W:0] lim_eff;

  assign lim_eff = (timeout_limit == '0) ? (TO_W+1)'(1) : {1'b0, timeout_limit};

  always_ff @(posedge clk) begin
    if (rst || !lnk_req) pend_cnt <= '0;
    else                 pend_cnt <= pend_cnt + (TO_W+1)'(1);
  end

  // R4
  launch_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFF_CTRL && reg_wdata[0] && !lnk_req) |=> lnk_req);

  // R5
  reply_ends_req_chk: assert property (@(posedge clk) disable iff (rst)
    (lnk_req && lnk_rsp_valid) |=> !lnk_req);

  // R8
  fields_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (lnk_req && !lnk_rsp_valid) |=>
      ($stable(lnk_addr) && $stable(lnk_cmd) && $stable(lnk_len)));

  // R9
  wait_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    lnk_req |-> (pend_cnt < lim_eff));

  // R10
  flush_aborts_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFF_CFG && reg_wdata == CFG_FLUSH) |=> !lnk_req);
endmodule

bind aux_req_engine aux_req_engine_chk #(.TO_W(TO_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .timeout_limit(timeout_limit), .lnk_req(lnk_req),
  .lnk_cmd(lnk_cmd), .lnk_addr(lnk_addr), .lnk_len(lnk_len),
  .lnk_rsp_valid(lnk_rsp_valid)
);

// File: tb/aux_req_engine_tb.sv
module aux_req_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int TO_W  = 16;
  localparam int IW    = $clog2(DEPTH);

  localparam logic [7:0] A_CFG = 8'h76, A_AD0 = 8'h7D, A_AD1 = 8'h7E,
    A_AD2 = 8'h7F, A_LEN = 8'h80, A_WD = 8'h81, A_RD = 8'h82,
    A_CTL = 8'h83, A_ST = 8'h84;

  // {cmd[3:0], addr[19:0], lenreg[7:0], result[2:0], count[4:0]}
  localparam int NVEC = 5;
  localparam logic [39:0] VEC [NVEC] = '{
    {4'h8, 20'h12345, 8'h03, 3'd3, 5'd0},
    {4'h9, 20'h00100, 8'h01, 3'd3, 5'd2},
    {4'h1, 20'h00050, 8'h80, 3'd5, 5'd0},
    {4'h0, 20'hFFFFF, 8'h0F, 3'd6, 5'd16},
    {4'h9, 20'hABCDE, 8'h02, 3'd2, 5'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [TO_W-1:0] timeout_limit = 16'd1000;
  logic lnk_req;
  logic [3:0] lnk_cmd;
  logic [19:0] lnk_addr;
  logic [4:0] lnk_len;
  logic [IW-1:0] lnk_tx_idx = 0;
  logic [7:0] lnk_tx_data;
  logic lnk_rx_valid = 0, lnk_rsp_valid = 0;
  logic [7:0] lnk_rx_data = 0;
  logic [2:0] lnk_rsp_status = 0;
  logic [4:0] lnk_rsp_count = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_req_engine #(.BUF_DEPTH(DEPTH), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .timeout_limit(timeout_limit), .lnk_req(lnk_req), .lnk_cmd(lnk_cmd),
    .lnk_addr(lnk_addr), .lnk_len(lnk_len), .lnk_tx_idx(lnk_tx_idx),
    .lnk_tx_data(lnk_tx_data), .lnk_rx_valid(lnk_rx_valid),
    .lnk_rx_data(lnk_rx_data), .lnk_rsp_valid(lnk_rsp_valid),
    .lnk_rsp_status(lnk_rsp_status), .lnk_rsp_count(lnk_rsp_count)
  );

  function automatic logic [7:0] pay(int k, int i);
    return 8'((k * 17 + i * 3 + 5) ^ 8'hC0);
  endfunction

  function automatic logic [7:0] rxb(int k, int i);
    return 8'(8'h40 + k * 16 + i);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  // Link responder: n reply bytes from base, then the reply pulse
  task automatic respond(int n, int kb, logic [2:0] st, logic [4:0] cnt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lnk_rx_valid = 1; lnk_rx_data = rxb(kb, i);
    end
    @(negedge clk);
    lnk_rx_valid = 0;
    lnk_rsp_valid = 1; lnk_rsp_status = st; lnk_rsp_count = cnt;
    @(negedge clk);
    lnk_rsp_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // Reset state
    chk("R11 lnk_req", 32'(lnk_req), 0);
    rd(A_CTL, v); chk("R11 ctrl", 32'(v), 0);
    rd(A_ST, v);  chk("R11 status", 32'(v), 0);
    rd(A_RD, v);  chk("R11 rdata", 32'(v), 0);

    // Vector-driven transactions
    for (int k = 0; k < NVEC; k++) begin
      logic [3:0] cmd; logic [19:0] ad; logic [7:0] lr;
      logic [2:0] st; logic [4:0] cn;
      int nb, nrx; bit isrd;
      {cmd, ad, lr, st, cn} = VEC[k];
      isrd = cmd[0];
      nb   = lr[7] ? 0 : int'(lr[3:0]) + 1;
      nrx  = isrd ? ((cn > 16) ? 16 : int'(cn)) : 2;

      wr(A_CFG, 8'hFF);
      wr(A_AD0, ad[7:0]);
      wr(A_AD1, ad[15:8]);
      wr(A_AD2, {cmd, ad[19:16]});
      wr(A_LEN, lr);
      if (!isrd) for (int i = 0; i < nb; i++) wr(A_WD, pay(k, i));

      rd(A_AD2, v); chk("R1 adr2 readback", 32'(v), 32'({cmd, ad[19:16]}));
      rd(A_LEN, v); chk("R1 len readback", 32'(v), 32'(lr));
      chk("R1 lnk_addr", 32'(lnk_addr), 32'(ad));
      chk("R1 lnk_cmd", 32'(lnk_cmd), 32'(cmd));
      chk("R2 lnk_len", 32'(lnk_len), 32'(nb));

      wr(A_CTL, 8'h01);
      chk("R4 lnk_req", 32'(lnk_req), 1);
      rd(A_CTL, v); chk("R4 ctrl busy", 32'(v), 1);
      rd(A_ST, v);  chk("R4 status clear", 32'(v), 0);

      wr(A_AD0, ~ad[7:0]);
      wr(A_LEN, 8'h05);
      chk("R8 addr frozen", 32'(lnk_addr), 32'(ad));
      chk("R8 len frozen", 32'(lnk_len), 32'(nb));

      if (!isrd) begin
        for (int i = 0; i < nb; i++) begin
          lnk_tx_idx = IW'(i);
          #1;
          chk("R3 payload byte", 32'(lnk_tx_data), 32'(pay(k, i)));
        end
      end

      respond(nrx, k, st, cn);
      chk("R5 req dropped", 32'(lnk_req), 0);
      rd(A_CTL, v); chk("R5 ctrl cleared", 32'(v), 0);
      rd(A_ST, v);  chk("R5 status", 32'(v), 32'({st, cn}));
      rd(A_AD0, v); chk("R8 adr0 kept", 32'(v), 32'(ad[7:0]));

      if (isrd) begin
        for (int i = 0; i < nrx; i++) begin
          rd(A_RD, v); chk("R6 reply byte", 32'(v), 32'(rxb(k, i)));
        end
        rd(A_RD, v); chk("R7 empty read", 32'(v), 0);
      end else begin
        rd(A_RD, v); chk("R6 write reply dropped", 32'(v), 0);
      end
    end

    // R8: payload write during flight ignored
    wr(A_CFG, 8'hFF);
    wr(A_AD2, 8'h00);
    wr(A_LEN, 8'h01);
    wr(A_WD, 8'h11);
    wr(A_CTL, 8'h01);
    wr(A_WD, 8'h22);
    respond(0, 0, 3'd3, 5'd0);
    wr(A_WD, 8'h33);
    wr(A_CTL, 8'h01);
    lnk_tx_idx = IW'(1);
    #1;
    chk("R8 payload not appended", 32'(lnk_tx_data), 32'h33);
    lnk_tx_idx = '0;
    #1;
    chk("R3 first payload", 32'(lnk_tx_data), 32'h11);
    respond(0, 0, 3'd3, 5'd0);

    // R9: timeout after exactly the limit
    timeout_limit = 16'd8;
    wr(A_CFG, 8'hFF);
    wr(A_CTL, 8'h01);
    begin
      int n = 0;
      while (lnk_req && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R9 pending cycles", 32'(n), 8);
    end
    rd(A_ST, v);  chk("R9 timeout status", 32'(v), 32'hE0);
    rd(A_CTL, v); chk("R9 ctrl cleared", 32'(v), 0);
    timeout_limit = 16'd1000;

    // R7 then R10: empty read does not consume, other cfg values ignored
    wr(A_CFG, 8'hFF);
    wr(A_AD2, 8'h91);
    rd(A_RD, v); chk("R7 empty before reply", 32'(v), 0);
    wr(A_CTL, 8'h01);
    respond(2, 7, 3'd3, 5'd2);
    rd(A_RD, v); chk("R7 first byte kept", 32'(v), 32'(rxb(7, 0)));
    wr(A_CFG, 8'h7F);
    rd(A_ST, v); chk("R10 other value no clear", 32'(v), 32'h62);
    wr(A_CFG, 8'hFF);
    rd(A_ST, v); chk("R10 status flushed", 32'(v), 0);
    rd(A_RD, v); chk("R10 reply flushed", 32'(v), 0);
    wr(A_CTL, 8'h01);
    chk("R10 launched", 32'(lnk_req), 1);
    wr(A_CFG, 8'hFF);
    chk("R10 abort", 32'(lnk_req), 0);
    rd(A_CTL, v); chk("R10 ctrl after abort", 32'(v), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule